// File: doc/BRIEF.md
# Fixed-Priority Memory Slot Arbiter

This block shares a single memory port among eight requesters. They are, in order of rank:

- a fast image stream
- a refresh engine
- a telemetry readout
- an array photometric stream
- a fast spectral stream
- a slow spectral stream
- a processor port
- a command port

Each requester signals a need for one memory transaction by pulsing its request bit. The arbiter latches that pulse as a pending request. When the memory is free, it awards the slot to the highest-ranked pending requester and holds the grant until the memory reports the transaction done.

Refresh is ranked as an ordinary requester, just below the image stream. The image stream therefore wins every contested slot, and refresh still beats all other sources. A saturating count of outstanding refresh requests raises a starvation flag when refresh has been held off too long. A busy flag tells the bus masters that the memory is occupied by someone other than the command port.

Top module: `mem_slot_arbiter`

## Requirements
- R1: While and after reset, grant is all zero, mem_busy is 0 and refresh_starved is 0.
- R2: A one-cycle pulse on req[i] sampled at a rising edge becomes pending at that edge. If the port is free, grant[i] is asserted after the next rising edge.
- R3: Requester index 0 (image) has the highest rank and index 7 (command) the lowest. The order is 0 image, 1 refresh, 2 telemetry, 3 array photometer, 4 fast spectral, 5 slow spectral, 6 processor, 7 command. Among pending requests, the lowest index is granted.
- R4: A grant is held unchanged until done is sampled high. A request of higher rank arriving meanwhile waits and does not pre-empt it.
- R5: At the edge where done is sampled high with a grant active, the next grant is chosen from the requests pending before that edge, back to back. If none are pending, grant returns to zero.
- R6: grant is one-hot or zero in every cycle, and it is zero when nothing is pending.
- R7: done sampled high while no grant is active has no effect.
- R8: mem_busy is 1 exactly when a grant other than grant[7] (command port) is active.
- R9: Each refresh request pulse adds one to an outstanding-refresh count, which saturates at STARVE_MAX (3). refresh_starved is 1 while the count equals STARVE_MAX. Granting refresh clears the count, and a refresh pulse at that same edge counts as 1.
- R10: Repeated pulses from a requester that is already pending merge into one pending request and yield a single grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 8 | Request pulses, one bit per requester, bit 0 highest rank |
| done | input | 1 | Current transaction has completed |
| grant | output | 8 | One-hot grant of the memory slot |
| mem_busy | output | 1 | Memory held by a source other than the command port |
| refresh_starved | output | 1 | Outstanding refresh count reached its limit |

## Verification
The bench first drives a burst in which every requester except the image stream asks at once. The resulting grant sequence separates a true rank order from any rotating or first-come scheme.

An image request is then injected while refresh holds the slot. This tells apart a design that holds until done from one that pre-empts. Refresh pulses are piled up behind a long image transaction to reach saturation, duplicate photometer pulses test the merging of pending requests, and done is pulsed with nothing granted.

A long run of sparse random requests and done pulses is compared on every clock against a behavioural model. This covers back-to-back handover and the simultaneous request-and-grant cases that directed tests miss.

// File: rtl/mem_slot_arbiter.sv
module mem_slot_arbiter #(
  parameter int N_REQ       = 8,
  parameter int REFRESH_IDX = 1,
  parameter int CMD_IDX     = 7,
  parameter int STARVE_MAX  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  input  logic             done,
  output logic [N_REQ-1:0] grant,
  output logic             mem_busy,
  output logic             refresh_starved
);
  localparam int CW = $clog2(STARVE_MAX + 1);
  localparam logic [CW-1:0] CMAX = CW'(STARVE_MAX);

  logic [N_REQ-1:0] pend, pick, take;
  logic [CW-1:0]    ref_cnt, ref_base;
  logic             free;

  assign free = ~|grant | done;
  assign take = free ? pick : '0;

  always_comb begin
    pick = '0;
    for (int i = N_REQ - 1; i >= 0; i--)
      if (pend[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
  end

  assign ref_base = take[REFRESH_IDX] ? '0 : ref_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      grant   <= '0;
      ref_cnt <= '0;
    end else begin
      pend <= (pend & ~take) | req;
      if (free) grant <= pick;
      if (req[REFRESH_IDX] && ref_base != CMAX) ref_cnt <= ref_base + 1'b1;
      else                                      ref_cnt <= ref_base;
    end
  end

  assign mem_busy        = |(grant & ~(N_REQ'(1) << CMD_IDX));
  assign refresh_starved = (ref_cnt == CMAX);

  // R6
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R4
  hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !done) |=> $stable(grant));

  // R3
  rank_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && grant != $past(grant)) |-> (($past(pend) & (grant - 1'b1)) == '0));

  // R6
  no_idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 || done) && pend == '0 |=> grant == '0);

  // R9
  starve_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_starved |-> pend[REFRESH_IDX]);

  // R8
  cmd_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant[CMD_IDX] |-> !mem_busy);
endmodule

// File: tb/sim_mem_slot_arbiter.sv
module sim_mem_slot_arbiter;
  logic       clk = 0, rst_n = 0, done = 0;
  logic [7:0] req = '0;
  logic [7:0] grant;
  logic       mem_busy, refresh_starved;

  int tests = 0, fails = 0, cyc = 0;
  int mg = -1, mcnt = 0;
  bit mpend [8];

  mem_slot_arbiter u0 (.clk(clk), .rst_n(rst_n), .req(req), .done(done),
    .grant(grant), .mem_busy(mem_busy), .refresh_starved(refresh_starved));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference, updated on the same edge as the design
  always @(posedge clk) begin
    int pick;
    cyc++;
    pick = -1;
    if (!rst_n) begin
      mg = -1; mcnt = 0;
      foreach (mpend[i]) mpend[i] = 0;
    end else begin
      if (mg < 0 || done) begin
        foreach (mpend[i]) if (mpend[i] && pick < 0) pick = i;
        mg = pick;
      end
      if (pick == 1) mcnt = 0;
      if (req[1] && mcnt < 3) mcnt++;
      foreach (mpend[i]) begin
        if (pick == i) mpend[i] = 0;
        if (req[i]) mpend[i] = 1;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    logic [7:0] eg;
    eg = (mg < 0) ? 8'h00 : 8'(1 << mg);
    chk(grant == eg, "R3 grant vs model", grant, eg);
    chk(mem_busy == (mg >= 0 && mg != 7), "R8 busy vs model", mem_busy, (mg >= 0 && mg != 7));
    chk(refresh_starved == (mcnt == 3), "R9 starved vs model", refresh_starved, (mcnt == 3));
  end

  task automatic pulse(input logic [7:0] m);
    req = m; @(negedge clk); req = '0;
  endtask
  task automatic finish_one();
    done = 1; @(negedge clk); done = 0;
  endtask

  initial begin
    #100000000;
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(grant == 0 && !mem_busy && !refresh_starved, "R1 reset state", grant, 0);
    rst_n = 1;
    @(negedge clk);
    chk(grant == 0, "R1 after reset", grant, 0);
    done = 1; @(negedge clk); done = 0;
    chk(grant == 0, "R7 stray done", grant, 0);

    pulse(8'hFE);
    chk(grant == 8'h00, "R2 latch cycle", grant, 0);
    @(negedge clk);
    chk(grant == 8'h02, "R2 refresh first", grant, 8'h02);
    chk(mem_busy == 1, "R8 busy on refresh", mem_busy, 1);
    pulse(8'h01);
    @(negedge clk);
    chk(grant == 8'h02, "R4 no preemption", grant, 8'h02);
    finish_one();
    chk(grant == 8'h01, "R5 image next", grant, 8'h01);
    for (int k = 2; k < 8; k++) begin
      finish_one();
      chk(grant == 8'(1 << k), "R3 rank order", grant, 1 << k);
    end
    chk(mem_busy == 0, "R8 command not busy", mem_busy, 0);
    finish_one();
    chk(grant == 0, "R5 empty after done", grant, 0);
    @(negedge clk);
    chk(grant == 0, "R6 no request no grant", grant, 0);

    pulse(8'h01);
    @(negedge clk);
    chk(grant == 8'h01, "R2 image grant", grant, 8'h01);
    for (int k = 0; k < 4; k++) pulse(8'h02);
    chk(refresh_starved == 1, "R9 saturated", refresh_starved, 1);
    pulse(8'h08); pulse(8'h08);
    finish_one();
    chk(grant == 8'h02 && !refresh_starved, "R9 cleared on grant", grant, 8'h02);
    finish_one();
    chk(grant == 8'h08, "R10 photometer", grant, 8'h08);
    finish_one();
    chk(grant == 0, "R10 single merged grant", grant, 0);

    for (int n = 0; n < 4000; n++) begin
      logic [7:0] r;
      r = '0;
      for (int b = 0; b < 8; b++) r[b] = ($urandom_range(0, 7) == 0);
      req = r;
      done = ($urandom_range(0, 2) == 0);
      @(negedge clk);
    end
    req = '0; done = 0;
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule